// File: doc/BRIEF.md
# Serial Test Pattern Generator and Checker

This block produces a provisioned serial test stream for a tributary channel and checks a returning stream against the same pattern. The generator emits one bit per accepted transfer. Its pattern can be one of three maximal-length pseudorandom sequences, a zero-limited variant of the 20-stage sequence, a one/zero toggle, a constant one, or a repeating 16-bit word taken from a configuration input.

The checker locks on without a seed from the generator. While hunting it loads the incoming bits into its own reference register. Once locked it runs the reference freely and compares each arriving bit with it. Mismatches go into a saturating counter that clears when read, and a burst of mismatches drops the lock so that hunting starts again. Three sticky status bits record a lock loss, any counted error and an external loss-of-frame flag. Software can poll them, or a per-bit mask can combine them into one interrupt line.

Both stream edges use a valid/ready handshake. On the generator side the downstream consumer applies back-pressure by holding `gen_ready` low. The offered bit then stays put and the sequence does not advance. The checker never applies back-pressure: `mon_ready` stays high, and only cycles with `mon_valid` high carry a bit.

Top module: `tpat_unit`

## Requirements
- R1: Pattern code 0, 1 and 2 select pseudorandom sequences whose next bit is the XOR of the bits 15 and 14, 20 and 3, or 23 and 18 transfers back. After reset every earlier bit counts as one, so the first code-0 bit is 0.
- R2: Pattern code 3 runs the code-1 sequence internally, but its output bit is forced to one whenever the 14 or more internal bits just before it were all zero.
- R3: Code 4 gives 1,0,1,0,… starting with 1. Code 5 gives all ones. Code 6 repeats `cfg_user` from bit 15 down to bit 0.
- R4: `gen_valid` is high from the first clock edge after reset. A bit moves only when `gen_valid` and `gen_ready` are both high. While `gen_ready` is low, `gen_bit` holds and the sequence does not skip. `mon_ready` stays high, and cycles with `mon_valid` low change nothing in the checker.
- R5: The checker first takes 23 bits into its reference and then needs 32 correct predictions in a row before `in_sync` rises. With a clean loop from reset, `in_sync` is low after 54 accepted bits and high after 55.
- R6: While `in_sync` is high, every mismatching bit adds one to `err_count`. Bits that arrive while hunting are never counted.
- R7: Lock is checked over consecutive 64-bit windows that start when lock is gained. The eighth error inside one window clears `in_sync` on that bit. Seven errors in a window, or eight split over a window boundary, keep the lock.
- R8: `err_count` is ERR_W bits wide (16 by default) and stops at all ones.
- R9: A cycle with `err_rd` high clears `err_count` at that clock edge.
- R10: `status` bit 0 is set on lock loss, bit 1 on any counted error, and bit 2 while `frame_lost` is high. A bit stays set until `sts_wr` is high with a one in the matching bit of `sts_wdata`. A set in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit is set with its `irq_mask` bit also set.
- R12: After a lock loss the checker hunts again and, on a clean stream, is back in lock 55 bits later.
- R13: During reset `in_sync`, `err_count`, `status` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 3 | Pattern code (0..6) |
| cfg_user | input | USER_W | Repeating user word, MSB sent first |
| gen_valid | output | 1 | Generator offers a bit |
| gen_ready | input | 1 | Consumer accepts the offered bit |
| gen_bit | output | 1 | Generated bit |
| mon_valid | input | 1 | Incoming bit present |
| mon_ready | output | 1 | Checker accepts (always high) |
| mon_bit | input | 1 | Incoming bit |
| frame_lost | input | 1 | External loss-of-frame flag |
| err_rd | input | 1 | Read strobe, clears the error count |
| err_count | output | ERR_W | Saturating error count |
| in_sync | output | 1 | Checker locked |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Write-one-to-clear data |
| irq_mask | input | 3 | Interrupt enables per status bit |
| status | output | 3 | Sticky status |
| irq | output | 1 | Interrupt |

## Verification
The generator is looped back into the checker for every pattern code. The 23-stage, 20-stage and zero-limited streams are compared bit by bit with an independent model, so a wrong tap or a missing zero limit shows up at once. Single errors spaced ten bits apart show that each mismatch is counted exactly once, and a run of errors during the hunt shows that the hunt does not count errors. Seven-error, boundary-split and eight-error bursts tell a correct window limit from an off-by-one or an unaligned window. A long run of spaced errors reaches counter saturation.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
  localparam int LFSR_W     = 23;
  localparam int QRSS_ZMAX  = 14;
  localparam int PERIOD_TAP = 15;

  typedef enum logic [2:0] {
    PAT_PRBS15 = 3'd0,
    PAT_PRBS20 = 3'd1,
    PAT_PRBS23 = 3'd2,
    PAT_QRSS   = 3'd3,
    PAT_ALT    = 3'd4,
    PAT_ONES   = 3'd5,
    PAT_USER   = 3'd6
  } pat_e;

  // next internal bit from history; h[0] is the newest bit
  function automatic logic lfsr_feed(input logic [LFSR_W-1:0] h, input logic [2:0] sel);
    logic f;
    case (pat_e'(sel))
      PAT_PRBS15:           f = (h[14:0] == 15'd0) ? 1'b1 : (h[14] ^ h[13]);
      PAT_PRBS20, PAT_QRSS: f = (h[19:0] == 20'd0) ? 1'b1 : (h[19] ^ h[2]);
      PAT_PRBS23:           f = (h == '0) ? 1'b1 : (h[22] ^ h[17]);
      default:              f = h[PERIOD_TAP];
    endcase
    return f;
  endfunction
endpackage

// File: rtl/tpat_ref.sv
module tpat_ref
  import tpat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       step,
  input  logic       load,
  input  logic       load_bit,
  output logic       pred
);
  localparam int ZW = $clog2(QRSS_ZMAX + 1);

  logic [LFSR_W-1:0] hist;
  logic [ZW-1:0]     zrun;
  logic              raw, push;

  always_comb begin
    raw  = lfsr_feed(hist, sel);
    pred = raw | ((sel == PAT_QRSS) && (zrun >= ZW'(QRSS_ZMAX)));
    push = load ? load_bit : raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '1;
      zrun <= '0;
    end else if (step) begin
      hist <= {hist[LFSR_W-2:0], push};
      zrun <= push ? '0 : ((zrun == '1) ? zrun : zrun + 1'b1);
    end
  end
endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
  import tpat_pkg::*;
#(
  parameter int USER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel,
  input  logic [USER_W-1:0] user,
  input  logic              ready,
  output logic              valid,
  output logic              bit_o
);
  localparam int PH_W = $clog2(USER_W);

  logic            valid_q, take, lfsr_bit;
  logic [PH_W-1:0] phase;

  assign valid = valid_q;
  assign take  = valid_q & ready;

  tpat_ref u_ref (
    .clk(clk), .rst_n(rst_n), .sel(sel), .step(take),
    .load(1'b0), .load_bit(1'b0), .pred(lfsr_bit)
  );

  always_comb begin
    case (pat_e'(sel))
      PAT_ALT:  bit_o = ~phase[0];
      PAT_ONES: bit_o = 1'b1;
      PAT_USER: bit_o = user[PH_W'(USER_W-1) - phase];
      default:  bit_o = lfsr_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      phase   <= '0;
    end else begin
      valid_q <= 1'b1;
      if (take) phase <= phase + 1'b1;
    end
  end

  // R4: an offered bit holds under back-pressure
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> ($stable(bit_o) || !$stable(sel) || !$stable(user)));
endmodule

// File: rtl/tpat_mon.sv
module tpat_mon
  import tpat_pkg::*;
#(
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int WIN_LIMIT = 8,
  parameter int ERR_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             rd_clr,
  output logic             sync_o,
  output logic [ERR_W-1:0] err_cnt,
  output logic             err_hit,
  output logic             los_hit
);
  localparam int FW = $clog2(LFSR_W + 1);
  localparam int MW = $clog2(SYNC_RUN);
  localparam int WW = $clog2(WIN_LEN);
  localparam int EW = $clog2(WIN_LIMIT + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic          sync_q, pred, miss;
  logic [FW-1:0] fill;
  logic [MW-1:0] match;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] win_err, win_err_nx;

  tpat_ref u_ref (
    .clk(clk), .rst_n(rst_n), .sel(sel), .step(in_valid),
    .load(~sync_q), .load_bit(in_bit), .pred(pred)
  );

  always_comb begin
    miss       = pred ^ in_bit;
    win_err_nx = win_err + EW'(miss);
    err_hit    = in_valid & sync_q & miss;
    los_hit    = in_valid & sync_q & (win_err_nx >= EW'(WIN_LIMIT));
  end

  assign sync_o = sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      fill    <= '0;
      match   <= '0;
      win_cnt <= '0;
      win_err <= '0;
    end else if (in_valid) begin
      if (!sync_q) begin
        if (fill != FW'(LFSR_W)) begin
          fill  <= fill + 1'b1;
          match <= '0;
        end else if (miss) begin
          match <= '0;
        end else if (match == MW'(SYNC_RUN - 1)) begin
          sync_q  <= 1'b1;
          match   <= '0;
          win_cnt <= '0;
          win_err <= '0;
        end else begin
          match <= match + 1'b1;
        end
      end else if (los_hit) begin
        sync_q <= 1'b0;
        fill   <= '0;
        match  <= '0;
      end else if (win_cnt == WW'(WIN_LEN - 1)) begin
        win_cnt <= '0;
        win_err <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        win_err <= win_err_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             err_cnt <= '0;
    else if (rd_clr)                        err_cnt <= err_hit ? ERR_W'(1) : '0;
    else if (err_hit && err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
  end

  // R8: a full count stays full until read
  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == ERR_MAX && !rd_clr) |=> (err_cnt == ERR_MAX));
  // R6: nothing is counted while hunting
  p_hunt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && !rd_clr) |=> $stable(err_cnt));
  // R7: a locked window never holds the limit of errors
  p_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (win_err < EW'(WIN_LIMIT)));
endmodule

// File: rtl/tpat_status.sv
module tpat_status #(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_i,
  input  logic          wr,
  input  logic [NB-1:0] wdata,
  input  logic [NB-1:0] mask,
  output logic [NB-1:0] sts,
  output logic          irq
);
  logic [NB-1:0] clr;

  assign clr = wr ? wdata : '0;
  assign irq = |(sts & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | set_i;
  end

  // R10: a set bit survives unless written with one
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~sts & $past(sts & ~clr)) == '0));
endmodule

// File: rtl/tpat_unit.sv
module tpat_unit
  import tpat_pkg::*;
#(
  parameter int USER_W    = 16,
  parameter int ERR_W     = 16,
  parameter int SYNC_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int WIN_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_sel,
  input  logic [USER_W-1:0] cfg_user,
  output logic              gen_valid,
  input  logic              gen_ready,
  output logic              gen_bit,
  input  logic              mon_valid,
  output logic              mon_ready,
  input  logic              mon_bit,
  input  logic              frame_lost,
  input  logic              err_rd,
  output logic [ERR_W-1:0]  err_count,
  output logic              in_sync,
  input  logic              sts_wr,
  input  logic [2:0]        sts_wdata,
  input  logic [2:0]        irq_mask,
  output logic [2:0]        status,
  output logic              irq
);
  logic err_hit, los_hit;

  assign mon_ready = 1'b1;

  tpat_gen #(.USER_W(USER_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .sel(cfg_sel), .user(cfg_user),
    .ready(gen_ready), .valid(gen_valid), .bit_o(gen_bit)
  );

  tpat_mon #(
    .SYNC_RUN(SYNC_RUN), .WIN_LEN(WIN_LEN), .WIN_LIMIT(WIN_LIMIT), .ERR_W(ERR_W)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .sel(cfg_sel), .in_valid(mon_valid),
    .in_bit(mon_bit), .rd_clr(err_rd), .sync_o(in_sync),
    .err_cnt(err_count), .err_hit(err_hit), .los_hit(los_hit)
  );

  tpat_status #(.NB(3)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_i({frame_lost, err_hit, los_hit}),
    .wr(sts_wr), .wdata(sts_wdata), .mask(irq_mask), .sts(status), .irq(irq)
  );

  // R10: dropping the lock always leaves the loss flag set
  p_los_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> status[0]);
endmodule

// File: tb/tpat_unit_test.sv
module tpat_unit_test;
  localparam int EW = 6;
  localparam int WATCHDOG = 190000;
  // {sel[46:44], user[43:28], nbits[27:8], injected[7:4], expected errors[3:0]}
  localparam logic [46:0] VEC [8] = '{
    {3'd0, 16'h0000, 20'd300,   4'd0, 4'd0},
    {3'd1, 16'h0000, 20'd300,   4'd3, 4'd3},
    {3'd2, 16'h0000, 20'd300,   4'd1, 4'd1},
    {3'd3, 16'h0000, 20'd40000, 4'd2, 4'd2},
    {3'd4, 16'h0000, 20'd200,   4'd0, 4'd0},
    {3'd5, 16'h0000, 20'd200,   4'd4, 4'd4},
    {3'd6, 16'hC3A5, 20'd300,   4'd5, 4'd5},
    {3'd6, 16'h0001, 20'd300,   4'd0, 4'd0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, gen_valid, gen_ready, gen_bit, mon_valid, mon_ready, mon_bit;
  logic frame_lost, err_rd, in_sync, sts_wr, irq;
  logic [2:0] cfg_sel, sts_wdata, irq_mask, status;
  logic [15:0] cfg_user;
  logic [EW-1:0] err_count;

  tpat_unit #(.ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_user(cfg_user),
    .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_bit(gen_bit),
    .mon_valid(mon_valid), .mon_ready(mon_ready), .mon_bit(mon_bit),
    .frame_lost(frame_lost), .err_rd(err_rd), .err_count(err_count),
    .in_sync(in_sync), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .irq_mask(irq_mask), .status(status), .irq(irq)
  );

  int total = 0, bad = 0, gen_bad = 0, nb = 0;
  logic [22:0] m_sr;
  int m_z, m_idx;
  logic [2:0] m_sel;
  logic [15:0] m_user;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic m_raw();
    case (m_sel)
      3'd0:    return m_sr[14] ^ m_sr[13];
      3'd2:    return m_sr[22] ^ m_sr[17];
      default: return m_sr[19] ^ m_sr[2];
    endcase
  endfunction

  function automatic logic m_expect();
    case (m_sel)
      3'd3:    return m_raw() | (m_z >= 14);
      3'd4:    return (m_idx % 2) == 0;
      3'd5:    return 1'b1;
      3'd6:    return m_user[15 - (m_idx % 16)];
      default: return m_raw();
    endcase
  endfunction

  task automatic m_step();
    logic r;
    r = m_raw();
    m_sr = {m_sr[21:0], r};
    m_z = r ? 0 : m_z + 1;
    m_idx++;
  endtask

  task automatic do_reset(input logic [2:0] s, input logic [15:0] u, input bit check_rst);
    rst_n = 1'b0; cfg_sel = s; cfg_user = u;
    gen_ready = 0; mon_valid = 0; mon_bit = 0; frame_lost = 0;
    err_rd = 0; sts_wr = 0; sts_wdata = 0; irq_mask = 0;
    repeat (3) @(negedge clk);
    if (check_rst) begin
      irq_mask = 3'b111;
      chk(in_sync === 1'b0 && irq === 1'b0, "R13 sync/irq in reset", int'(in_sync), 0);
      chk(err_count === '0 && status === 3'b000, "R13 count/status in reset", int'(err_count), 0);
      irq_mask = 0;
    end
    m_sr = '1; m_z = 0; m_idx = 0; m_sel = s; m_user = u; gen_bad = 0; nb = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one transfer through the loop; entered and left at a falling edge
  task automatic xfer(input logic inj);
    if (gen_bit !== m_expect()) gen_bad++;
    gen_ready = 1; mon_valid = 1; mon_bit = gen_bit ^ inj;
    @(negedge clk);
    m_step();
    nb++;
    gen_ready = 0; mon_valid = 0;
  endtask

  task automatic run_span(input int stop, input int lo, input int hi, input int step);
    while (nb < stop) xfer(nb >= lo && nb <= hi && ((nb - lo) % step) == 0);
  endtask

  initial begin
    #(WATCHDOG * 10);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R13 reset state and R4 valid after release
    do_reset(3'd0, 16'h0, 1'b1);
    chk(gen_valid === 1'b1 && mon_ready === 1'b1, "R4 valid/ready after reset", int'(gen_valid), 1);

    // table walk: loopback per pattern code, spaced single errors after bit 100
    for (int v = 0; v < 8; v++) begin
      int n_inj;
      do_reset(VEC[v][46:44], VEC[v][43:28], 1'b0);
      n_inj = int'(VEC[v][7:4]);
      if (n_inj > 0) run_span(int'(VEC[v][27:8]), 100, 100 + 10 * (n_inj - 1), 10);
      else           run_span(int'(VEC[v][27:8]), 0, -1, 1);
      chk(gen_bad == 0, "R1/R2/R3 generated sequence", gen_bad, 0);
      chk(in_sync === 1'b1, "R5 lock on loopback", int'(in_sync), 1);
      chk(int'(err_count) == int'(VEC[v][3:0]), "R6 counted errors", int'(err_count), int'(VEC[v][3:0]));
    end

    // R5 exact lock time
    do_reset(3'd0, 16'h0, 1'b0);
    run_span(54, 0, -1, 1);
    chk(in_sync === 1'b0, "R5 not locked after 54", int'(in_sync), 0);
    xfer(1'b0);
    chk(in_sync === 1'b1, "R5 locked after 55", int'(in_sync), 1);

    // R6 errors during the hunt are not counted
    do_reset(3'd1, 16'h0, 1'b0);
    run_span(120, 0, 9, 1);
    chk(err_count === '0, "R6 hunt errors ignored", int'(err_count), 0);
    chk(in_sync === 1'b1, "R5 lock after noisy hunt", int'(in_sync), 1);

    // R4 back-pressure and idle monitor cycles
    for (int i = 0; i < 6; i++) begin
      gen_ready = 0; mon_valid = 0; mon_bit = ~mon_bit;
      @(negedge clk);
      if (gen_bit !== m_expect()) gen_bad++;
    end
    chk(gen_bad == 0, "R4 bit held under back-pressure", gen_bad, 0);
    run_span(160, 0, -1, 1);
    chk(gen_bad == 0 && err_count === '0, "R4 no skip, idle input ignored", int'(err_count), 0);
    chk(in_sync === 1'b1, "R4 lock kept over idle cycles", int'(in_sync), 1);

    // R7 window behaviour; lock gained at bit 55, windows 55..118, 119..182, 183..246
    do_reset(3'd2, 16'h0, 1'b0);
    run_span(55, 0, -1, 1);
    run_span(119, 60, 66, 1);
    chk(in_sync === 1'b1 && int'(err_count) == 7, "R7 seven in window keeps lock", int'(err_count), 7);
    run_span(200, 179, 186, 1);
    chk(in_sync === 1'b1, "R7 burst over boundary keeps lock", int'(in_sync), 1);
    chk(int'(err_count) == 15, "R6 boundary burst counted", int'(err_count), 15);
    run_span(203, 200, 202, 1);
    chk(in_sync === 1'b1, "R7 seventh in window keeps lock", int'(in_sync), 1);
    xfer(1'b1);
    chk(in_sync === 1'b0, "R7 eighth in window drops lock", int'(in_sync), 0);
    chk(int'(err_count) == 19, "R6 eighth error counted", int'(err_count), 19);
    chk(status === 3'b011, "R10 loss and error flags", int'(status), 3);

    // R12 relock timing
    run_span(258, 0, -1, 1);
    chk(in_sync === 1'b0 && int'(err_count) == 19, "R12 still hunting after 54", int'(in_sync), 0);
    xfer(1'b0);
    chk(in_sync === 1'b1, "R12 relocked after 55", int'(in_sync), 1);

    // R9 read clears
    err_rd = 1; @(negedge clk); err_rd = 0;
    chk(err_count === '0, "R9 cleared on read", int'(err_count), 0);

    // R10 / R11 status and interrupt
    irq_mask = 3'b000; @(negedge clk);
    chk(irq === 1'b0, "R11 masked off", int'(irq), 0);
    irq_mask = 3'b001; @(negedge clk);
    chk(irq === 1'b1, "R11 loss enabled", int'(irq), 1);
    sts_wr = 1; sts_wdata = 3'b001; @(negedge clk); sts_wr = 0;
    chk(status === 3'b010, "R10 write one clears bit 0 only", int'(status), 2);
    chk(irq === 1'b0, "R11 cleared source drops irq", int'(irq), 0);
    frame_lost = 1; @(negedge clk); frame_lost = 0;
    irq_mask = 3'b100; @(negedge clk);
    chk(status === 3'b110 && irq === 1'b1, "R10/R11 frame flag raises irq", int'(status), 6);
    frame_lost = 1; sts_wr = 1; sts_wdata = 3'b100; @(negedge clk);
    frame_lost = 0; sts_wr = 0;
    chk(status[2] === 1'b1, "R10 set wins over clear", int'(status[2]), 1);

    // R8 saturation with the bench width
    do_reset(3'd0, 16'h0, 1'b0);
    run_span(55, 0, -1, 1);
    run_span(755, 60, 750, 10);
    chk(in_sync === 1'b1, "R7 spaced errors keep lock", int'(in_sync), 1);
    chk(int'(err_count) == (1 << EW) - 1, "R8 count saturates", int'(err_count), (1 << EW) - 1);
    err_rd = 1; @(negedge clk); err_rd = 0;
    chk(err_count === '0, "R9 clear from full", int'(err_count), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule